// File: doc/BRIEF.md
# IEEE Double Operand Screen

This block inspects a 64-bit IEEE-754 double-precision operand before it reaches an execution unit and decides whether the operand must be refused with an invalid-operation trap. It does no arithmetic and never alters the operand. Each check is presented with a one-cycle valid strobe. The verdict appears as registered single-cycle pulses in the following cycle.

Three screening policies are selectable per operand:
- **Plain arithmetic** refuses denormals, infinities and NaNs.
- **Comparison** refuses denormals and NaNs but lets infinities through.
- **Software completion** refuses only denormals, marks the trap as software-completable, and can be silenced by the flush-inputs-to-zero control.

A sticky invalid bit collects every verdict that raises the invalid flag. Only reset clears it.

Top module: `fp_operand_screen`

## Requirements
- R1: After reset, trap_req, inv_flag, swc_qual and sticky_inv are all 0.
- R2: In plain mode (mode = 2'b00), an operand with exponent field [62:52] equal to zero and fraction field [51:0] nonzero (a denormal) gives trap_req = 1 with inv_flag = 0 and swc_qual = 0, whatever the value of ftz.
- R3: In plain mode, an operand whose exponent field is all ones (infinity or NaN) gives trap_req = 1 and inv_flag = 1, and sticky_inv is 1 from that cycle on.
- R4: In comparison mode (mode = 2'b01), an all-ones exponent with a zero fraction (infinity) passes with no trap. With a nonzero fraction (NaN) it gives trap_req = 1 and inv_flag = 1 and sets sticky_inv.
- R5: In comparison mode, a denormal gives trap_req = 1 with inv_flag = 0 and swc_qual = 0.
- R6: In software-completion mode (mode = 2'b10) with ftz = 0, a denormal gives trap_req = 1 and swc_qual = 1 with inv_flag = 0; infinities and NaNs pass. The denormal test is that twice the operand minus one, taken modulo 2^64, is below 0x1F_FFFF_FFFF_FFFF.
- R7: In software-completion mode with ftz = 1, no operand traps.
- R8: Zeros and normal numbers never trap in any mode, and the sign bit [63] affects no classification.
- R9: While chk_valid is 0, the next cycle shows no trap_req, inv_flag or swc_qual, and sticky_inv does not change, whatever the operand.
- R10: Once set, sticky_inv stays 1 until reset, through passing operands and traps without the invalid flag.
- R11: Mode 2'b11 screens exactly as plain mode.
- R12: Verdict outputs appear in the clock cycle after the one in which chk_valid is sampled high, and last exactly one cycle unless chk_valid is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | Operand presented for screening this cycle |
| operand | input | 64 | IEEE double operand under inspection |
| mode | input | 2 | Policy: 00 plain, 01 comparison, 10 software completion, 11 as plain |
| ftz | input | 1 | Flush-inputs-to-zero control |
| trap_req | output | 1 | Invalid-operation trap request pulse |
| inv_flag | output | 1 | Invalid flag pulse; also sets the sticky bit |
| swc_qual | output | 1 | Trap carries the software-completion qualifier |
| sticky_inv | output | 1 | Sticky invalid bit |

## Verification
The sticky bit is written in the same edge that raises a trap pulse. The interesting cases are the ones where a trap arrives without the invalid flag: plain or comparison denormals, and software-completion denormals. These must leave sticky_inv exactly as it was, whether it was still clear or already set. The bench runs each such trap before and after sticky_inv has been set by a NaN or an infinity, and checks trap_req, inv_flag, swc_qual and sticky_inv together in the cycle after the strobe. A mid-run reset then confirms that the same edge can set sticky_inv again from clear.

// File: rtl/fos_pkg.sv
// Package: shared types for the operand screen.
// Assumes a binary IEEE-754 layout of sign, biased exponent and fraction.
package fos_pkg;

    typedef enum logic [1:0] {
        POL_PLAIN = 2'b00,
        POL_CMP   = 2'b01,
        POL_SOFT  = 2'b10,
        POL_ALT   = 2'b11
    } policy_e;

    // Field classification of one operand
    typedef struct packed {
        logic exp_zero;   // biased exponent is all zeros
        logic exp_ones;   // biased exponent is all ones
        logic frac_nz;    // fraction field nonzero
        logic tiny_soft;  // denormal by the software-completion test
    } opclass_t;

    // Screening verdict for one operand
    typedef struct packed {
        logic trap;
        logic inv;
        logic swc;
    } verdict_t;

endpackage

// File: rtl/fos_classify.sv
// Module: fos_classify
// Splits an operand into its fields and classifies it. Purely combinational.
// Assumes the sign is the MSB, the exponent sits above the fraction, and the
// fraction occupies the low FRAC_W bits.
// The TINY_ARITH parameter picks how the software-completion denormal test is built.
module fos_classify #(
    parameter int EXP_W      = 11,
    parameter int FRAC_W     = 52,
    parameter bit TINY_ARITH = 1'b1,
    localparam int DATA_W    = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0] op,
    output fos_pkg::opclass_t cls
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              tiny;

    // Field extraction and exponent and fraction tests
    always_comb begin
        exp_f        = op[DATA_W-2 -: EXP_W];
        frac_f       = op[FRAC_W-1:0];
        cls.exp_zero = (exp_f == '0);
        cls.exp_ones = (exp_f == '1);
        cls.frac_nz  = (frac_f != '0);
        cls.tiny_soft = tiny;
    end

    generate
        if (TINY_ARITH) begin : g_arith
            localparam logic [DATA_W-1:0] TINY_LIM = {{(DATA_W-FRAC_W-1){1'b0}}, {(FRAC_W+1){1'b1}}};
            logic [DATA_W-1:0] dbl_m1;
            // Doubling drops the sign; the wrap of zero minus one excludes zeros
            always_comb begin
                dbl_m1 = {op[DATA_W-2:0], 1'b0} - {{(DATA_W-1){1'b0}}, 1'b1};
                tiny   = (dbl_m1 < TINY_LIM);
            end
        end else begin : g_field
            // Direct field form of the same denormal test
            always_comb begin
                tiny = (op[MAG_W-1 -: EXP_W] == '0) && (op[FRAC_W-1:0] != '0);
            end
        end
    endgenerate

endmodule

// File: rtl/fos_policy.sv
// Module: fos_policy
// Maps an operand class, a policy select and the flush control to a verdict.
// Purely combinational. The reserved policy code screens as plain.
module fos_policy (
    input  fos_pkg::opclass_t cls,
    input  logic [1:0]        mode,
    input  logic              ftz,
    output fos_pkg::verdict_t vd
);
    import fos_pkg::*;

    logic denorm;
    logic nan;
    policy_e pol;

    // Policy decision per operand class
    always_comb begin
        pol    = policy_e'(mode);
        denorm = cls.exp_zero & cls.frac_nz;
        nan    = cls.exp_ones & cls.frac_nz;
        vd     = '0;
        unique case (pol)
            POL_CMP: begin
                vd.trap = denorm | nan;
                vd.inv  = nan;
            end
            POL_SOFT: begin
                vd.trap = cls.tiny_soft & ~ftz;
                vd.swc  = cls.tiny_soft & ~ftz;
            end
            default: begin
                vd.trap = denorm | cls.exp_ones;
                vd.inv  = cls.exp_ones;
            end
        endcase
    end

endmodule

// File: rtl/fp_operand_screen.sv
// Module: fp_operand_screen (top)
// Screens one IEEE operand per strobe and registers the verdict.
// The verdict appears as single-cycle pulses in the following cycle.
// A sticky invalid bit collects every verdict that raises the invalid flag.
// Assumes a synchronous active-low reset.
module fp_operand_screen #(
    parameter int EXP_W      = 11,
    parameter int FRAC_W     = 52,
    parameter bit TINY_ARITH = 1'b1,
    localparam int DATA_W    = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [1:0]        mode,
    input  logic              ftz,
    output logic              trap_req,
    output logic              inv_flag,
    output logic              swc_qual,
    output logic              sticky_inv
);
    import fos_pkg::*;

    opclass_t cls;
    verdict_t vd;
    verdict_t vd_q;
    logic     sticky_q;

    fos_classify #(
        .EXP_W     (EXP_W),
        .FRAC_W    (FRAC_W),
        .TINY_ARITH(TINY_ARITH)
    ) u_cls (
        .op (operand),
        .cls(cls)
    );

    fos_policy u_pol (
        .cls (cls),
        .mode(mode),
        .ftz (ftz),
        .vd  (vd)
    );

    // Verdict register: a pulse only when an operand was presented
    always_ff @(posedge clk) begin
        if (!rst_n)         vd_q <= '0;
        else if (chk_valid) vd_q <= vd;
        else                vd_q <= '0;
    end

    // Sticky invalid accumulation, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)                  sticky_q <= 1'b0;
        else if (chk_valid && vd.inv) sticky_q <= 1'b1;
    end

    // Output drive
    always_comb begin
        trap_req   = vd_q.trap;
        inv_flag   = vd_q.inv;
        swc_qual   = vd_q.swc;
        sticky_inv = sticky_q;
    end

endmodule

// File: rtl/fp_operand_screen_chk.sv
// Module: fp_operand_screen_chk
// Protocol and policy checker, attached to the top with bind.
module fp_operand_screen_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chk_valid,
    input logic [DATA_W-1:0] operand,
    input logic [1:0]        mode,
    input logic              ftz,
    input logic              trap_req,
    input logic              inv_flag,
    input logic              swc_qual,
    input logic              sticky_inv
);
    logic [EXP_W-1:0]  e_f;
    logic [FRAC_W-1:0] f_f;
    assign e_f = operand[DATA_W-2 -: EXP_W];
    assign f_f = operand[FRAC_W-1:0];

    a_r2_plain_denorm: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && mode == 2'b00 && e_f == '0 && f_f != '0 |=> trap_req && !inv_flag && !swc_qual);
    a_r3_inv_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        inv_flag |-> sticky_inv);
    a_r4_cmp_inf_pass: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && mode == 2'b01 && e_f == '1 && f_f == '0 |=> !trap_req);
    a_r6_swc_no_inv: assert property (@(posedge clk) disable iff (!rst_n)
        swc_qual |-> trap_req && !inv_flag);
    a_r7_ftz_silent: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && mode == 2'b10 && ftz |=> !trap_req);
    a_r8_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && operand[DATA_W-2:0] == '0 |=> !trap_req);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !trap_req && !inv_flag && !swc_qual);
    a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_inv |=> sticky_inv);
    a_r10_sticky_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_inv) |-> inv_flag);
    a_r12_flag_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
        inv_flag |-> trap_req);
endmodule

bind fp_operand_screen fp_operand_screen_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .operand(operand),
    .mode(mode), .ftz(ftz), .trap_req(trap_req), .inv_flag(inv_flag),
    .swc_qual(swc_qual), .sticky_inv(sticky_inv)
);

// File: tb/fp_operand_screen_test.sv
module fp_operand_screen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  mode = 2'b00;
    logic        ftz = 1'b0;
    logic        trap_req, inv_flag, swc_qual, sticky_inv;

    int checks = 0;
    int fails  = 0;
    logic exp_sticky = 1'b0;

    localparam logic [63:0] DEN_MIN = 64'h0000_0000_0000_0001;
    localparam logic [63:0] DEN_MAX = 64'h000F_FFFF_FFFF_FFFF;
    localparam logic [63:0] DEN_NEG = 64'h8008_0000_0000_0000;
    localparam logic [63:0] INF_P   = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] INF_N   = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] NAN_Q   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] NAN_S   = 64'hFFF0_0000_0000_0001;
    localparam logic [63:0] ONE     = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] NEG_MIN = 64'h8010_0000_0000_0000;
    localparam logic [63:0] ZERO_P  = 64'h0000_0000_0000_0000;
    localparam logic [63:0] ZERO_N  = 64'h8000_0000_0000_0000;

    always #2.5 clk = ~clk;

    fp_operand_screen uut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .operand(operand),
        .mode(mode), .ftz(ftz), .trap_req(trap_req), .inv_flag(inv_flag),
        .swc_qual(swc_qual), .sticky_inv(sticky_inv)
    );

    task automatic check_bit(input logic act, input logic expv, input string what);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", what, act, expv);
        end
    endtask

    task automatic check_all(input logic et, input logic ei, input logic es, input string tag);
        check_bit(trap_req,   et,         {tag, " trap_req"});
        check_bit(inv_flag,   ei,         {tag, " inv_flag"});
        check_bit(swc_qual,   es,         {tag, " swc_qual"});
        check_bit(sticky_inv, exp_sticky, {tag, " sticky_inv"});
    endtask

    // One strobe, verdict sampled one cycle later
    task automatic screen(input logic [63:0] op, input logic [1:0] md, input logic f,
                          input logic et, input logic ei, input logic es, input string tag);
        @(negedge clk);
        operand = op; mode = md; ftz = f; chk_valid = 1'b1;
        @(negedge clk);
        chk_valid = 1'b0;
        if (ei) exp_sticky = 1'b1;
        check_all(et, ei, es, tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; chk_valid = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        exp_sticky = 1'b0;
        check_all(1'b0, 1'b0, 1'b0, "R1 reset");
    endtask

    task automatic t_plain_denorm();
        screen(DEN_MIN, 2'b00, 1'b0, 1, 0, 0, "R2 plain denorm min");
        screen(DEN_MAX, 2'b00, 1'b1, 1, 0, 0, "R2 plain denorm max ftz");
        screen(DEN_NEG, 2'b00, 1'b0, 1, 0, 0, "R2 plain denorm neg");
    endtask

    task automatic t_cmp_denorm();
        screen(DEN_MIN, 2'b01, 1'b0, 1, 0, 0, "R5 cmp denorm");
        screen(DEN_NEG, 2'b01, 1'b1, 1, 0, 0, "R5 cmp denorm neg ftz");
    endtask

    task automatic t_soft();
        screen(DEN_MIN, 2'b10, 1'b0, 1, 0, 1, "R6 soft denorm min");
        screen(DEN_MAX, 2'b10, 1'b0, 1, 0, 1, "R6 soft denorm max");
        screen(DEN_NEG, 2'b10, 1'b0, 1, 0, 1, "R6 soft denorm neg");
        screen(INF_P,   2'b10, 1'b0, 0, 0, 0, "R6 soft inf passes");
        screen(NAN_S,   2'b10, 1'b0, 0, 0, 0, "R6 soft nan passes");
        screen(DEN_MIN, 2'b10, 1'b1, 0, 0, 0, "R7 soft ftz denorm");
        screen(DEN_NEG, 2'b10, 1'b1, 0, 0, 0, "R7 soft ftz denorm neg");
    endtask

    task automatic t_zero_normal();
        for (int m = 0; m < 4; m++) begin
            screen(ZERO_P,  2'(m), 1'b0, 0, 0, 0, "R8 +0");
            screen(ZERO_N,  2'(m), 1'b0, 0, 0, 0, "R8 -0");
            screen(ONE,     2'(m), 1'b0, 0, 0, 0, "R8 one");
            screen(NEG_MIN, 2'(m), 1'b0, 0, 0, 0, "R8 neg min normal");
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        operand = NAN_Q; mode = 2'b00; chk_valid = 1'b0;
        @(negedge clk);
        check_all(0, 0, 0, "R9 idle nan plain");
        operand = DEN_MIN; mode = 2'b10;
        @(negedge clk);
        check_all(0, 0, 0, "R9 idle denorm soft");
    endtask

    task automatic t_cmp_special();
        screen(INF_P, 2'b01, 1'b0, 0, 0, 0, "R4 cmp +inf passes");
        screen(INF_N, 2'b01, 1'b0, 0, 0, 0, "R4 cmp -inf passes");
        screen(NAN_Q, 2'b01, 1'b0, 1, 1, 0, "R4 cmp nan traps");
    endtask

    task automatic t_sticky_hold();
        screen(ONE,     2'b00, 1'b0, 0, 0, 0, "R10 hold normal");
        screen(DEN_MIN, 2'b00, 1'b0, 1, 0, 0, "R10 hold plain denorm");
        screen(DEN_MIN, 2'b10, 1'b0, 1, 0, 1, "R10 hold soft denorm");
        @(negedge clk); @(negedge clk);
        check_all(0, 0, 0, "R10 hold idle");
    endtask

    task automatic t_plain_special();
        screen(INF_N, 2'b00, 1'b0, 1, 1, 0, "R3 plain -inf");
        screen(NAN_S, 2'b00, 1'b1, 1, 1, 0, "R3 plain nan ftz");
    endtask

    task automatic t_alt_mode();
        screen(DEN_MIN, 2'b11, 1'b0, 1, 0, 0, "R11 alt denorm");
        screen(INF_P,   2'b11, 1'b0, 1, 1, 0, "R11 alt inf");
        screen(DEN_MIN, 2'b11, 1'b1, 1, 0, 0, "R11 alt denorm ftz");
    endtask

    task automatic t_pulse();
        @(negedge clk);
        operand = DEN_MIN; mode = 2'b10; ftz = 1'b0; chk_valid = 1'b1;
        check_all(0, 0, 0, "R12 not before edge");
        @(negedge clk);
        operand = ONE;
        check_all(1, 0, 1, "R12 first of back-to-back");
        @(negedge clk);
        chk_valid = 1'b0;
        check_all(0, 0, 0, "R12 second of back-to-back");
        @(negedge clk);
        check_all(0, 0, 0, "R12 pulse ends");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_plain_denorm();
        t_cmp_denorm();
        t_soft();
        t_zero_normal();
        t_idle();
        t_cmp_special();
        t_sticky_hold();
        do_reset();
        t_pulse();
        t_plain_special();
        t_alt_mode();
        do_reset();
        t_alt_mode();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule